// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides two integers over several clock cycles, producing one quotient bit per cycle with a single subtractor. A request is made by pulsing `start` while the block is idle, with the operands and the signed/unsigned select valid in that cycle. The block raises `busy` and works through the division. It then pulses `done` for one cycle, with the quotient, the remainder and two flags valid. These outputs hold their values until the next completion.

The datapath is a single shift register. Its upper part holds the partial remainder and its lower half gathers quotient bits. The register is shifted once before the loop. Each loop step then tries a subtraction on the upper part and keeps either the difference or the old value before shifting in the new quotient bit. A last step moves only the upper part right by one place. For signed requests, the operands are turned into magnitudes first and the signs are put back at the end. A zero divisor and the single overflowing signed case are flagged and return fixed results, with no change in latency.

Top module: `seq_divider`

## Requirements
- R1: After reset, `busy`, `done`, `quotient`, `remainder`, `div_by_zero` and `overflow` are all 0.
- R2: A `start` accepted while idle makes `busy` high from the next cycle. `done` goes high for exactly one cycle, W+1 clock edges after the accepting edge, and `busy` is low in that cycle.
- R3: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own result, and no further operation is begun.
- R4: With `is_signed`=0, `quotient` = dividend / divisor and `remainder` = dividend mod divisor, both taken as unsigned. Operands with the top bit set are treated as large positive values (for example 0xFFFFFFFF / 2 = 0x7FFFFFFF rem 1).
- R5: With `is_signed`=1, the operands are two's complement. The quotient is truncated toward zero and is negative when the operand signs differ. The remainder takes the sign of the dividend (for example -7 / 2 = -3 rem -1, and 7 / -2 = -3 rem 1).
- R6: A divisor of 0 completes in the normal W+1 cycles. It sets `div_by_zero`, returns an all-ones `quotient`, and returns the unmodified dividend as `remainder`, in either mode.
- R7: With `is_signed`=1, the most negative value divided by -1 sets `overflow`. The quotient is the most negative value and the remainder is 0. `overflow` is 0 in all other cases.
- R8: `quotient`, `remainder` and both flags change only in the cycle that `done` is high, and hold between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only while idle |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | W | Dividend, sampled with an accepted start |
| divisor | input | W | Divisor, sampled with an accepted start |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient of the last completed operation |
| remainder | output | W | Remainder of the last completed operation |
| div_by_zero | output | 1 | Last operation had a zero divisor |
| overflow | output | 1 | Last operation was most-negative by -1, signed |

## Verification
The assertions assume that `start` is a clean synchronous level. They also assume that reset is held until the clock runs, so the latency counter in the checker starts from a known idle state. The bench drives every input at the falling edge and samples at the falling edge. It keeps operands stable only in the cycle of `start`, which is all the block needs, and deliberately pulses `start` during a busy interval to exercise the ignore rule. Expected results come from the language's own integer division and modulo, with the zero-divisor and overflow cases written out by hand.

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero,
  output logic         overflow
);
  localparam int CW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIX} state_t;
  state_t st;

  logic [2*W:0] acc;
  logic [W:0]   dsr;
  logic [CW-1:0] cnt;
  logic         neg_q, neg_r, dbz, ovf;
  logic [W-1:0] dvd_raw;

  wire a_neg = is_signed & dividend[W-1];
  wire b_neg = is_signed & divisor[W-1];
  wire [W-1:0] a_mag = a_neg ? -dividend : dividend;
  wire [W-1:0] b_mag = b_neg ? -divisor : divisor;
  wire accept = start && (st == IDLE);

  wire [W:0]   hi   = acc[2*W:W];
  wire [W+1:0] trial = {1'b0, hi} - {1'b0, dsr};
  wire         fits = ~trial[W+1];
  wire [W:0]   kept = fits ? trial[W:0] : hi;

  wire [W-1:0] q_mag = acc[W-1:0];
  wire [W-1:0] r_mag = acc[2*W:W+1];

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= IDLE;
      acc         <= '0;
      dsr         <= '0;
      cnt         <= '0;
      neg_q       <= 1'b0;
      neg_r       <= 1'b0;
      dbz         <= 1'b0;
      ovf         <= 1'b0;
      dvd_raw     <= '0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (accept) begin
          acc     <= {{W{1'b0}}, a_mag, 1'b0};
          dsr     <= {1'b0, b_mag};
          cnt     <= '0;
          neg_q   <= a_neg ^ b_neg;
          neg_r   <= a_neg;
          dbz     <= (divisor == '0);
          ovf     <= is_signed && (dividend == {1'b1, {(W-1){1'b0}}}) && (divisor == '1);
          dvd_raw <= dividend;
          st      <= RUN;
        end
        RUN: begin
          acc <= {kept[W-1:0], acc[W-1:0], fits};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= FIX;
        end
        FIX: begin
          quotient    <= dbz ? '1 : (neg_q ? -q_mag : q_mag);
          remainder   <= dbz ? dvd_raw : (neg_r ? -r_mag : r_mag);
          div_by_zero <= dbz;
          overflow    <= ovf;
          done        <= 1'b1;
          st          <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seq_divider_chk.sv
module seq_divider_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero,
  input logic         overflow
);
  localparam int LW = $clog2(W + 3);
  logic [LW-1:0] lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy) lat <= lat + 1'b1;
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat == LW'(W + 1)));
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));
  assert_zero_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '1));
  assert_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overflow) |-> (quotient == {1'b1, {(W-1){1'b0}}} && remainder == '0 && !div_by_zero));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero) && $stable(overflow)) || done);
endmodule

bind seq_divider seq_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder),
  .div_by_zero(div_by_zero), .overflow(overflow)
);

// File: tb/tb_seq_divider.sv
module tb_seq_divider;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_signed = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, div_by_zero, overflow;
  logic [W-1:0] quotient, remainder;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  seq_divider #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input logic s, input string tag);
    logic [W-1:0] eq, er;
    logic edz, eov;
    int n;
    edz = (b == '0);
    eov = s && (a == {1'b1, {(W-1){1'b0}}}) && (b == '1);
    if (edz) begin eq = '1; er = a; end
    else if (eov) begin eq = a; er = '0; end
    else if (s) begin eq = $signed(a) / $signed(b); er = $signed(a) % $signed(b); end
    else begin eq = a / b; er = a % b; end
    @(negedge clk);
    dividend = a; divisor = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; dividend = '0; divisor = '0;
    chk(busy === 1'b1, {tag, " R2 busy"}, W'(busy), 1);
    n = 1;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(n == W + 2, {tag, " R2 latency"}, W'(n), W'(W + 2));
    chk(busy === 1'b0, {tag, " R2 busy low at done"}, W'(busy), 0);
    chk(quotient === eq, {tag, " quotient"}, quotient, eq);
    chk(remainder === er, {tag, " remainder"}, remainder, er);
    chk(div_by_zero === edz, {tag, " R6 flag"}, W'(div_by_zero), W'(edz));
    chk(overflow === eov, {tag, " R7 flag"}, W'(overflow), W'(eov));
    @(negedge clk);
    chk(done === 1'b0, {tag, " R2 done one cycle"}, W'(done), 0);
  endtask

  task automatic t_reset;
    chk(busy === 0 && done === 0, "R1 busy/done", {busy, done}, 0);
    chk(quotient === 0 && remainder === 0, "R1 data", quotient | remainder, 0);
    chk(div_by_zero === 0 && overflow === 0, "R1 flags", {div_by_zero, overflow}, 0);
  endtask

  task automatic t_unsigned;
    run_div(7, 2, 0, "R4 7/2");
    run_div(100, 7, 0, "R4 100/7");
    run_div(3, 10, 0, "R4 3/10");
    run_div(32'hFFFF_FFFF, 2, 0, "R4 big/2");
    run_div(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 max/max");
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 0, "R4 msb/ones unsigned");
    run_div(12345, 1, 0, "R4 /1");
  endtask

  task automatic t_signed;
    run_div(-7, 2, 1, "R5 -7/2");
    run_div(7, -2, 1, "R5 7/-2");
    run_div(-7, -2, 1, "R5 -7/-2");
    run_div(-100, 9, 1, "R5 -100/9");
    run_div(32'h8000_0000, 2, 1, "R5 min/2");
    run_div(-6, 3, 1, "R5 exact");
  endtask

  task automatic t_zero;
    run_div(1234, 0, 0, "R6 unsigned /0");
    run_div(-55, 0, 1, "R6 signed /0");
  endtask

  task automatic t_overflow;
    run_div(32'h8000_0000, 32'hFFFF_FFFF, 1, "R7 min/-1");
    run_div(32'h8000_0001, 32'hFFFF_FFFF, 1, "R7 near-min/-1");
  endtask

  task automatic t_busy_start;
    int n;
    @(negedge clk);
    dividend = 50; divisor = 6; is_signed = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    dividend = 9; divisor = 3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(quotient === 8, "R3 quotient of first op", quotient, 8);
    chk(remainder === 2, "R3 remainder of first op", remainder, 2);
    @(negedge clk);
    chk(busy === 0, "R3 no second op", W'(busy), 0);
  endtask

  task automatic t_hold;
    logic [W-1:0] q0, r0;
    run_div(1000, 3, 0, "R8 setup");
    q0 = quotient; r0 = remainder;
    dividend = 77; divisor = 0; is_signed = 1;
    repeat (5) @(negedge clk);
    chk(quotient === q0, "R8 quotient held", quotient, q0);
    chk(remainder === r0, "R8 remainder held", remainder, r0);
    chk(div_by_zero === 0, "R8 flag held", W'(div_by_zero), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_unsigned();
    t_signed();
    t_zero();
    t_overflow();
    t_busy_start();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog R2 actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule